// File: doc/BRIEF.md
# Firmware Hub Read Initiator

This block is the host-side master for read cycles on a 4-bit multiplexed firmware-hub bus. A client supplies a 4-bit device select, a 28-bit byte address and a size code through a valid/ready handshake. The block then sends the framed header: a start code while the frame strobe is low, the select, seven address nibbles and a size nibble. After that it performs a two-cycle handover of the bus to the target.

While the target owns the bus, the block waits through any number of wait codes until it sees a ready code. It then assembles one byte from the next two nibbles, low nibble first, and presents it on a one-cycle strobe. This group of waits, ready and data repeats once for each byte of the transfer. After the last byte the target gets two more cycles to hand the bus back. The block then drives the idle code again and pulses `done`.

If a ready code does not arrive within `WAIT_LIMIT` consecutive sync cycles, the read is abandoned. The block holds its drivers off for one extra cycle, then returns to idle and pulses `done` together with `err`.

Top module: `fwh_read_master`

## Requirements
- R1: In idle the block raises `req_ready`, holds `bus_frame_n` high and drives 1111b with `bus_oe` high. A request is taken only on a cycle where `req_valid` and `req_ready` are both high, and the header begins in the following cycle.
- R2: The first header cycle holds `bus_frame_n` low for exactly one cycle and drives 1101b. The next cycle drives the select nibble.
- R3: The seven cycles after the select drive the address nibbles: bits 27:24 first and bits 3:0 last.
- R4: The size nibble is 0000b when `req_size`=00 (1 byte), 0100b when it is 01 (16 bytes) and 0101b when it is 10 (32 bytes). The value 11 is sent and handled as a 1-byte read.
- R5: After the size nibble the block drives 1111b for one cycle, then lowers `bus_oe` in the next cycle.
- R6: In a sync cycle, any code other than 0000b (for example the wait code 0101b) keeps the block waiting. After 0000b, the next two cycles supply the low nibble and then the high nibble. `byte_valid` is high, with the assembled byte on `byte_data`, in the cycle after the high nibble.
- R7: A read delivers exactly 1, 16 or 32 bytes as selected, and each byte follows its own sync/data group.
- R8: After the final high nibble, `bus_oe` stays low for two more cycles. The block then drives 1111b with `bus_oe` high and pulses `done` for one cycle with `err` low.
- R9: If `WAIT_LIMIT` consecutive sync cycles pass without 0000b, the block abandons the read. It keeps `bus_oe` low for one more cycle, then enters idle with `done` and `err` both high for one cycle. With `WAIT_LIMIT-1` waits the byte is still received.
- R10: While a read is in progress, `req_ready` is low, and changes on `req_valid`, `req_sel`, `req_addr` and `req_size` do not alter the header being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_sel | input | 4 | Device select nibble |
| req_addr | input | 28 | Byte address |
| req_size | input | 2 | 00: 1 byte, 01: 16 bytes, 10: 32 bytes |
| bus_frame_n | output | 1 | Frame strobe, low in the start cycle |
| bus_out | output | 4 | Nibble driven by the host |
| bus_oe | output | 1 | Host drives the nibble bus when high |
| bus_in | input | 4 | Nibble received from the bus |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| done | output | 1 | One-cycle end-of-read pulse |
| err | output | 1 | High with `done` when the read timed out |

## Verification
The assertions check on every cycle that a low frame strobe only appears with the start code and lasts one cycle. They also check that the drivers are always released just after a 1111b cycle, that a byte strobe only follows a high-nibble capture, that `err` never appears without `done`, and that the wait counter stays under its limit. The exact header nibble order, the byte values and count, the two-cycle handbacks, and the timeout boundary at `WAIT_LIMIT-1` versus `WAIT_LIMIT` waits can only be shown by the bench's scenarios. The bench compares those cycle by cycle against its own timeline.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
  localparam logic [3:0] NIB_START = 4'b1101;
  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_IDLE  = 4'b1111;
  localparam int         HDR_LEN   = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_SYNC, ST_DLO, ST_DHI, ST_ETAR1, ST_ETAR2, ST_ABORT
  } rd_state_e;

  function automatic logic [3:0] size_code(input logic [1:0] sz);
    case (sz)
      2'b01:   return 4'b0100;
      2'b10:   return 4'b0101;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [5:0] byte_total(input logic [1:0] sz);
    case (sz)
      2'b01:   return 6'd16;
      2'b10:   return 6'd32;
      default: return 6'd1;
    endcase
  endfunction

  // header slot 0 start, 1 select, 2..8 address high first, 9 size, else idle code
  function automatic logic [3:0] hdr_nibble(input logic [3:0] sel, input logic [27:0] addr,
                                            input logic [1:0] sz, input logic [3:0] idx);
    int sh;
    if (idx == 4'd0) return NIB_START;
    if (idx == 4'd1) return sel;
    if (idx >= 4'd2 && idx <= 4'd8) begin
      sh = 4 * (8 - int'(idx));
      return addr[sh +: 4];
    end
    if (idx == 4'd9) return size_code(sz);
    return NIB_IDLE;
  endfunction
endpackage

// File: rtl/fwh_wait_timer.sv
module fwh_wait_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign hit = tick && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (tick && !hit)  cnt <= cnt + 1'b1;
  end

  a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));
endmodule

// File: rtl/fwh_byte_asm.sv
module fwh_byte_asm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_lo,
  input  logic       cap_hi,
  input  logic [3:0] nib,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  logic [3:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q       <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= cap_hi;
      if (cap_lo) lo_q <= nib;
      if (cap_hi) byte_data <= {nib, lo_q};
    end
  end

  a_r6_strobe_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(cap_hi));
endmodule

// File: rtl/fwh_read_master.sv
module fwh_read_master
  import fwh_pkg::*;
#(
  parameter int WAIT_LIMIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_sel,
  input  logic [27:0] req_addr,
  input  logic [1:0]  req_size,
  output logic        bus_frame_n,
  output logic [3:0]  bus_out,
  output logic        bus_oe,
  input  logic [3:0]  bus_in,
  output logic        byte_valid,
  output logic [7:0]  byte_data,
  output logic        done,
  output logic        err
);
  localparam logic [3:0] HDR_LAST = 4'(HDR_LEN - 1);

  rd_state_e   st;
  logic [3:0]  hdr_idx;
  logic [3:0]  sel_q;
  logic [27:0] addr_q;
  logic [1:0]  size_q;
  logic [5:0]  bytes_left;
  logic        done_q, err_q;

  // named events
  logic accept, hdr_last, rdy_seen, sync_wait, tmo_hit, byte_last;
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hdr_last  = (st == ST_HDR) && (hdr_idx == HDR_LAST);
  assign rdy_seen  = (st == ST_SYNC) && (bus_in == NIB_READY);
  assign sync_wait = (st == ST_SYNC) && !rdy_seen;
  assign byte_last = (st == ST_DHI) && (bytes_left == 6'd1);

  assign bus_frame_n = !((st == ST_HDR) && (hdr_idx == 4'd0));
  assign bus_oe      = (st == ST_IDLE) || ((st == ST_HDR) && !hdr_last);
  assign bus_out     = (st == ST_HDR) ? hdr_nibble(sel_q, addr_q, size_q, hdr_idx) : NIB_IDLE;
  assign done        = done_q;
  assign err         = err_q;

  fwh_wait_timer #(.LIMIT(WAIT_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_SYNC), .tick(sync_wait), .hit(tmo_hit)
  );

  fwh_byte_asm u_asm (
    .clk(clk), .rst_n(rst_n),
    .cap_lo(st == ST_DLO), .cap_hi(st == ST_DHI), .nib(bus_in),
    .byte_valid(byte_valid), .byte_data(byte_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      hdr_idx    <= '0;
      sel_q      <= '0;
      addr_q     <= '0;
      size_q     <= '0;
      bytes_left <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          st         <= ST_HDR;
          hdr_idx    <= '0;
          sel_q      <= req_sel;
          addr_q     <= req_addr;
          size_q     <= req_size;
          bytes_left <= byte_total(req_size);
        end
        ST_HDR: begin
          hdr_idx <= hdr_idx + 1'b1;
          if (hdr_last) st <= ST_SYNC;
        end
        ST_SYNC: begin
          if (rdy_seen)     st <= ST_DLO;
          else if (tmo_hit) st <= ST_ABORT;
        end
        ST_DLO: st <= ST_DHI;
        ST_DHI: begin
          bytes_left <= bytes_left - 1'b1;
          st <= byte_last ? ST_ETAR1 : ST_SYNC;
        end
        ST_ETAR1: st <= ST_ETAR2;
        ST_ETAR2: begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        ST_ABORT: begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r2_start_code: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_frame_n |-> (bus_out == NIB_START && bus_oe));
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_frame_n |=> bus_frame_n);
  a_r5_release_after_tar: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> $past(bus_out) == NIB_IDLE);
  a_r1_ready_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_frame_n && bus_oe && bus_out == NIB_IDLE));
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_fwh_read_master.sv
module sim_fwh_read_master;
  localparam int LIM = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_sel = '0;
  logic [27:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        bus_frame_n, bus_oe, byte_valid, done, err;
  logic [3:0]  bus_out;
  logic [3:0]  bus_in = 4'hF;
  logic [7:0]  byte_data;

  always #4 clk = ~clk;

  fwh_read_master #(.WAIT_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_addr(req_addr), .req_size(req_size),
    .bus_frame_n(bus_frame_n), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .byte_valid(byte_valid), .byte_data(byte_data), .done(done), .err(err)
  );

  typedef struct packed {
    logic       rv;
    logic       noise;
    logic [3:0] din;
    logic       fn;
    logic       oe;
    logic [3:0] dout;
    logic       bv;
    logic [7:0] bd;
    logic       dn;
    logic       er;
    logic       rr;
  } cyc_t;

  cyc_t  q[$];
  string tq[$];
  int    n_cmp = 0, n_bad = 0, cyc = 0;
  logic  active = 1'b0;
  logic [3:0]  b_sel;
  logic [27:0] b_addr;
  logic [1:0]  b_size;
  logic        p_bv = 1'b0, p_dn = 1'b0, p_er = 1'b0;
  logic [7:0]  p_bd = '0;

  function automatic logic [7:0] dat(input int b, input logic [27:0] a);
    return a[7:0] ^ 8'(b * 29 + 7);
  endfunction

  task automatic add(input logic rv, input logic noise, input logic [3:0] din,
                     input logic fn, input logic oe, input logic [3:0] dout,
                     input logic rr, input string tag);
    cyc_t e;
    e = '{rv:rv, noise:noise, din:din, fn:fn, oe:oe, dout:dout,
          bv:p_bv, bd:p_bd, dn:p_dn, er:p_er, rr:rr};
    p_bv = 1'b0; p_dn = 1'b0; p_er = 1'b0;
    q.push_back(e);
    tq.push_back(tag);
  endtask

  // one read: w0 waits before byte 0, wr before every later byte
  task automatic run_txn(input logic [3:0] sel, input logic [27:0] addr, input logic [1:0] sz,
                         input int w0, input int wr, input logic noise_on);
    int nbytes;
    logic [3:0] nib;
    logic [7:0] d;
    b_sel = sel; b_addr = addr; b_size = sz;
    add(0, 0, 4'hF, 1, 1, 4'hF, 1, "R1");
    add(0, 0, 4'hF, 1, 1, 4'hF, 1, "R1");
    add(1, 0, 4'hF, 1, 1, 4'hF, 1, "R1");
    for (int i = 0; i < 12; i++) begin
      if (i == 0) nib = 4'b1101;
      else if (i == 1) nib = sel;
      else if (i <= 8) nib = 4'((addr >> (4 * (8 - i))) & 28'hF);
      else if (i == 9) nib = (sz == 2'b01) ? 4'b0100 : (sz == 2'b10) ? 4'b0101 : 4'b0000;
      else nib = 4'hF;
      add(noise_on && i >= 3 && i <= 5, noise_on && i >= 3 && i <= 5, 4'hF,
          i != 0, i != 11, nib, 0,
          noise_on && i >= 3 && i <= 5 ? "R10" : i < 2 ? "R2" : i < 9 ? "R3" : i == 9 ? "R4" : "R5");
    end
    nbytes = (sz == 2'b01) ? 16 : (sz == 2'b10) ? 32 : 1;
    for (int b = 0; b < nbytes; b++) begin
      int w;
      w = (b == 0) ? w0 : wr;
      if (w >= LIM) begin
        for (int k = 0; k < LIM; k++) add(0, 0, 4'b0101, 1, 0, 4'hF, 0, "R9");
        add(0, 0, 4'hF, 1, 0, 4'hF, 0, "R9");
        p_dn = 1'b1; p_er = 1'b1;
        add(0, 0, 4'hF, 1, 1, 4'hF, 1, "R9");
        return;
      end
      for (int k = 0; k < w; k++) add(0, 0, 4'b0101, 1, 0, 4'hF, 0, "R6");
      d = dat(b, addr);
      add(0, 0, 4'b0000, 1, 0, 4'hF, 0, "R6");
      add(0, 0, d[3:0], 1, 0, 4'hF, 0, "R6");
      add(0, 0, d[7:4], 1, 0, 4'hF, 0, "R7");
      p_bv = 1'b1; p_bd = d;
    end
    add(0, 0, 4'hF, 1, 0, 4'hF, 0, "R8");
    add(0, 0, 4'hF, 1, 0, 4'hF, 0, "R8");
    p_dn = 1'b1;
    add(0, 0, 4'hF, 1, 1, 4'hF, 1, "R8");
  endtask

  always @(negedge clk) begin
    cyc_t e;
    string tag;
    logic bad;
    if (active && q.size() > 0) begin
      e = q.pop_front();
      tag = tq.pop_front();
      bad = (bus_frame_n !== e.fn) || (bus_oe !== e.oe) || (e.oe && bus_out !== e.dout) ||
            (byte_valid !== e.bv) || (e.bv && byte_data !== e.bd) ||
            (done !== e.dn) || (err !== e.er) || (req_ready !== e.rr);
      n_cmp++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s: act fn=%b oe=%b out=%h bv=%b bd=%h dn=%b er=%b rr=%b exp fn=%b oe=%b out=%h bv=%b bd=%h dn=%b er=%b rr=%b",
                 tag, bus_frame_n, bus_oe, bus_out, byte_valid, byte_data, done, err, req_ready,
                 e.fn, e.oe, e.dout, e.bv, e.bd, e.dn, e.er, e.rr);
      end
      req_valid <= e.rv;
      req_sel   <= e.noise ? ~b_sel  : b_sel;
      req_addr  <= e.noise ? ~b_addr : b_addr;
      req_size  <= e.noise ? ~b_size : b_size;
      bus_in    <= e.din;
    end else begin
      req_valid <= 1'b0;
      bus_in    <= 4'hF;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (!(req_ready === 1 && bus_frame_n === 1 && bus_oe === 1 && bus_out === 4'hF &&
          byte_valid === 0 && done === 0 && err === 0)) begin
      n_bad++;
      $display("FAIL R1 reset: act rr=%b fn=%b oe=%b out=%h bv=%b dn=%b er=%b exp 1 1 1 f 0 0 0",
               req_ready, bus_frame_n, bus_oe, bus_out, byte_valid, done, err);
    end
    rst_n = 1'b1;
    @(negedge clk);
    active = 1'b1;
    run_txn(4'h3, 28'hA5C3_1E7, 2'b00, 2, 0, 0);       drain(); // R2 R3 R4 R6 R8
    run_txn(4'hC, 28'h0F1_2345, 2'b01, 0, 1, 1);       drain(); // R7 R10
    run_txn(4'h9, 28'h7654_321, 2'b10, 3, 0, 0);       drain(); // R7 32 bytes
    run_txn(4'h1, 28'h123_4567, 2'b00, LIM - 1, 0, 0); drain(); // R9 boundary, still ok
    run_txn(4'h5, 28'hBEE_F00D, 2'b01, 0, LIM, 0);     drain(); // R9 abort on byte 1
    run_txn(4'hE, 28'h000_0001, 2'b00, LIM, 0, 0);     drain(); // R9 abort on byte 0
    run_txn(4'h2, 28'hFED_CBA9, 2'b11, 1, 0, 0);       drain(); // R4 reserved size as 1 byte
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule